// File: doc/BRIEF.md
# Pipelined Converter Self-Calibration Sequencer

This block runs the digital self-calibration of a pipelined analog-to-digital converter. A calibration request input is sampled on falling clock edges. Once it has been seen high on three falling edges in a row, with reset released, the block raises a busy flag. It then works through the calibrated front-end stages, starting with the stage nearest the uncalibrated back end and moving toward the sample-and-hold. This way each stage is measured by a back end that has already been corrected. For every stage the block waits a programmable settle/average interval. It then raises a measurement request and waits for a valid strobe carrying a signed error word. It writes that word into a small coefficient memory, where the measurement path can read coefficients that are already stored.

While busy is high, converted data passing through the block is muted and flagged invalid. A calibrated flag is set only when a complete run ends, and conversions without it are flagged out of specification. Pulling the active-low reset low aborts a run in progress and wipes every coefficient. The block then waits in idle until the request has been seen low and has qualified again.

Top module: `cal_sequencer`

## Requirements
- R1: A run starts only after `cal_req_i` has been high at three consecutive falling clock edges with `rst_n` high. `busy_o` is first high in the clock cycle that follows the rising edge after the third such falling edge. Two falling edges start nothing.
- R2: `busy_o` stays high from the start of a run until the coefficient of the last stage has been written. It is low in the cycle after that write.
- R3: Stages are measured in the order 3, 2, 1, 0 on `meas_stage_o`, with code 3, 2 and 1 for the third, second and first multiplying stages and code 0 for the sample-and-hold. No other code is ever requested.
- R4: `meas_req_o` stays high until `meas_valid_i` is seen at a rising edge. `meas_err_i` is then written to the entry of the stage being measured, and `coef_o` shows entry `coef_sel_i` without delay. A stage's coefficient can be read while the next stage toward the front is being measured.
- R5: `rst_n` low at a rising edge sets `busy_o` and `calibrated_o` low and clears every coefficient to zero. This holds even when it coincides with the final coefficient write.
- R6: After a reset the run does not resume, even if `cal_req_i` stays high. The request must be seen low while idle and then qualify again.
- R7: Request activity while busy is ignored. The run length is unchanged, and if the request is still high when the run ends, no new run starts.
- R8: Each stage takes `SETTLE_CYC` settle cycles, then one cycle plus the response wait in measurement. With valid answered after L extra cycles, `busy_o` is high for N_STAGES*(SETTLE_CYC+L+1) cycles. The default gives 1,490,000 cycles with single-cycle responses.
- R9: While `busy_o` is high, `data_valid_o` is 0 and `data_o` is all zeros. Otherwise `data_o` equals `conv_data_i` and `data_valid_o` equals `conv_valid_i`.
- R10: `calibrated_o` goes high only as `busy_o` falls at the end of a complete run, and it is cleared at the start of a run. `data_inspec_o` is high only when `data_valid_o` and `calibrated_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; request sampled on falling edges, all else on rising edges |
| rst_n | input | 1 | Active-low reset; aborts and wipes coefficients |
| cal_req_i | input | 1 | Calibration request |
| busy_o | output | 1 | High while a calibration run is in progress |
| calibrated_o | output | 1 | High after a complete run, until reset or a new run |
| meas_req_o | output | 1 | Measurement request for the current stage |
| meas_stage_o | output | $clog2(N_STAGES) | Stage being calibrated (0 = sample-and-hold) |
| meas_valid_i | input | 1 | Measurement result valid |
| meas_err_i | input | ERR_W | Signed measured error word |
| coef_sel_i | input | $clog2(N_STAGES) | Coefficient read select |
| coef_o | output | ERR_W | Coefficient of the selected stage |
| conv_data_i | input | DATA_W | Converted data from the pipeline |
| conv_valid_i | input | 1 | Converted data valid |
| data_o | output | DATA_W | Data out, zero while busy |
| data_valid_o | output | 1 | Data valid, forced low while busy |
| data_inspec_o | output | 1 | Data valid and converter calibrated |

## Verification
The case of interest is a reset arriving in the same rising edge as the valid strobe of the sample-and-hold. At that edge a final coefficient write and run completion compete with an abort. The bench drives the last valid and pulls reset low half a cycle ahead of that edge, following a run that left the calibrated flag set. It then expects busy and the calibrated flag low and all four coefficients to read zero. A second case places a fresh request qualification inside a running calibration and judges it by an unchanged busy length and no restart afterwards.

// File: rtl/cal_seq_pkg.sv
// Shared types for the calibration sequencer.
package cal_seq_pkg;
    // Sequencer phases: idle, settle/average wait, measurement handshake.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_MEAS   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cal_req_qualifier.sv
// Qualifies the calibration request: it must be high on REQ_EDGES falling
// clock edges in a row. A lock keeps one request from starting more than
// one run. The lock is set by reset and at each start, and is released only
// when the request is seen low while idle.
// Assumes: request is quasi-static with respect to the clock.
module cal_req_qualifier #(
    parameter int REQ_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    output logic qual_o,
    output logic start_o
);
    localparam int QW = $clog2(REQ_EDGES + 1);
    localparam logic [QW-1:0] QMAX = QW'(REQ_EDGES);

    logic [QW-1:0] edge_cnt;
    logic          lock;

    // Count consecutive falling edges with the request high, saturating.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (!req_i) begin
            edge_cnt <= '0;
        end else if (edge_cnt != QMAX) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign qual_o  = (edge_cnt == QMAX);
    assign start_o = qual_o && !lock && !busy_i;

    // Hold the lock from reset or start until the request drops while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b1;
        end else if (start_o) begin
            lock <= 1'b1;
        end else if (!busy_i && !req_i) begin
            lock <= 1'b0;
        end
    end

    AST_LOCK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> lock); // R7
endmodule

// File: rtl/cal_stage_fsm.sv
// Walks the calibrated stages from the back (N_STAGES-1) to the front (0).
// For each stage it waits SETTLE_CYC cycles, then holds a measurement
// request until valid arrives, and strobes a coefficient write. Calibrated
// is set on completion of the front stage.
// Assumes: SETTLE_CYC >= 1; start_i is only asserted while idle.
module cal_stage_fsm
    import cal_seq_pkg::*;
#(
    parameter int N_STAGES   = 4,
    parameter int SETTLE_CYC = 372499
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          meas_valid_i,
    output logic          busy_o,
    output logic          calibrated_o,
    output logic          meas_req_o,
    output logic [(N_STAGES > 1 ? $clog2(N_STAGES) : 1)-1:0] stage_o,
    output logic          wr_en_o
);
    localparam int SW = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
    localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [SW-1:0] BACK_ID  = SW'(N_STAGES - 1);

    seq_state_t    state;
    logic [CW-1:0] settle_cnt;
    logic [SW-1:0] stage;

    // Phase, settle counter, stage index and calibrated flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            settle_cnt   <= '0;
            stage        <= '0;
            calibrated_o <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state        <= ST_SETTLE;
                        settle_cnt   <= '0;
                        stage        <= BACK_ID;
                        calibrated_o <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SET_LAST) begin
                        state <= ST_MEAS;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_MEAS: begin
                    if (meas_valid_i) begin
                        if (stage == '0) begin
                            state        <= ST_IDLE;
                            calibrated_o <= 1'b1;
                        end else begin
                            stage      <= stage - 1'b1;
                            settle_cnt <= '0;
                            state      <= ST_SETTLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (state != ST_IDLE);
    assign meas_req_o = (state == ST_MEAS);
    assign wr_en_o    = meas_req_o && meas_valid_i;
    assign stage_o    = stage;

    AST_BACK_STAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> (stage_o == BACK_ID)); // R3
    AST_STAGE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && stage_o != '0) |=> (stage_o == $past(stage_o) - 1'b1)); // R3
    AST_SETTLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (settle_cnt <= SET_LAST)); // R8
    AST_IDLE_AFTER_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && stage_o == '0) |=> !busy_o); // R2
endmodule

// File: rtl/cal_coef_store.sv
// Coefficient memory: one signed word per calibrated stage, written by the
// sequencer and read combinationally by the measurement path. Reset wipes
// every entry and takes precedence over a write in the same cycle.
// Assumes: N_ENT is small (register-based storage).
module cal_coef_store #(
    parameter int N_ENT = 4,
    parameter int W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [(N_ENT > 1 ? $clog2(N_ENT) : 1)-1:0] wr_idx_i,
    input  logic [W-1:0]          wr_data_i,
    input  logic [(N_ENT > 1 ? $clog2(N_ENT) : 1)-1:0] rd_idx_i,
    output logic [W-1:0]          rd_data_o
);
    localparam int AW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [W-1:0] mem [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        // Per-entry register: wiped by reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en_i && wr_idx_i == AW'(g)) begin
                mem[g] <= wr_data_i;
            end
        end

        AST_CLEAR_ON_RESET: assert property (@(posedge clk)
            !rst_n |=> (mem[g] == '0)); // R5
    end

    assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/cal_out_mute.sv
// Output qualification: mutes converted data while calibrating and flags
// conversions as in specification only once a calibration has completed.
// Assumes: data path is combinational through this block.
module cal_out_mute #(
    parameter int DATA_W = 14
) (
    input  logic              busy_i,
    input  logic              calibrated_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              inspec_o
);
    // Select muted or live data and derive the quality flags.
    always_comb begin
        data_o   = busy_i ? '0 : data_i;
        valid_o  = valid_i && !busy_i;
        inspec_o = valid_o && calibrated_i;
    end
endmodule

// File: rtl/cal_sequencer.sv
// Top of the calibration sequencer: request qualification, back-to-front
// stage sequencing, coefficient storage and output muting.
// Assumes: a measurement engine answers each meas_req_o with one
// meas_valid_i cycle; rst_n is synchronous to clk.
module cal_sequencer #(
    parameter int N_STAGES   = 4,
    parameter int ERR_W      = 12,
    parameter int DATA_W     = 14,
    parameter int SETTLE_CYC = 372499,
    parameter int REQ_EDGES  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_req_i,
    output logic                 busy_o,
    output logic                 calibrated_o,
    output logic                 meas_req_o,
    output logic [(N_STAGES > 1 ? $clog2(N_STAGES) : 1)-1:0] meas_stage_o,
    input  logic                 meas_valid_i,
    input  logic [ERR_W-1:0]     meas_err_i,
    input  logic [(N_STAGES > 1 ? $clog2(N_STAGES) : 1)-1:0] coef_sel_i,
    output logic [ERR_W-1:0]     coef_o,
    input  logic [DATA_W-1:0]    conv_data_i,
    input  logic                 conv_valid_i,
    output logic [DATA_W-1:0]    data_o,
    output logic                 data_valid_o,
    output logic                 data_inspec_o
);
    localparam int SW = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;

    logic          qual_w;
    logic          start_w;
    logic          wr_en_w;
    logic [SW-1:0] stage_w;

    cal_req_qualifier #(.REQ_EDGES(REQ_EDGES)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (cal_req_i),
        .busy_i  (busy_o),
        .qual_o  (qual_w),
        .start_o (start_w)
    );

    cal_stage_fsm #(.N_STAGES(N_STAGES), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .meas_valid_i (meas_valid_i),
        .busy_o       (busy_o),
        .calibrated_o (calibrated_o),
        .meas_req_o   (meas_req_o),
        .stage_o      (stage_w),
        .wr_en_o      (wr_en_w)
    );

    cal_coef_store #(.N_ENT(N_STAGES), .W(ERR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_w),
        .wr_idx_i  (stage_w),
        .wr_data_i (meas_err_i),
        .rd_idx_i  (coef_sel_i),
        .rd_data_o (coef_o)
    );

    cal_out_mute #(.DATA_W(DATA_W)) u_mute (
        .busy_i       (busy_o),
        .calibrated_i (calibrated_o),
        .data_i       (conv_data_i),
        .valid_i      (conv_valid_i),
        .data_o       (data_o),
        .valid_o      (data_valid_o),
        .inspec_o     (data_inspec_o)
    );

    assign meas_stage_o = stage_w;

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(qual_w)); // R1
    AST_CAL_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calibrated_o) |-> $fell(busy_o)); // R10
    AST_NO_DATA_DURING_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |-> !data_valid_o); // R9
    AST_REQ_HELD_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && !meas_valid_i) |=> (meas_req_o && $stable(meas_stage_o))); // R4
endmodule

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NST        = 4;
    localparam int SET        = 5;
    localparam int EW         = 12;
    localparam int DW         = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_req = 1'b0;
    logic          busy, calibrated, meas_req;
    logic [1:0]    meas_stage;
    logic          meas_valid = 1'b0;
    logic [EW-1:0] meas_err = '0;
    logic [1:0]    coef_sel = '0;
    logic [EW-1:0] coef;
    logic [DW-1:0] conv_data = '0;
    logic          conv_valid = 1'b0;
    logic [DW-1:0] data_out;
    logic          data_valid, data_inspec;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    int run_id  = 0;
    int idx     = 0;
    int busy_cnt = 0;
    bit abort_last = 1'b0;
    bit done = 1'b0;

    cal_sequencer #(.N_STAGES(NST), .ERR_W(EW), .DATA_W(DW), .SETTLE_CYC(SET)) u_cal_sequencer (
        .clk(clk), .rst_n(rst_n), .cal_req_i(cal_req),
        .busy_o(busy), .calibrated_o(calibrated),
        .meas_req_o(meas_req), .meas_stage_o(meas_stage),
        .meas_valid_i(meas_valid), .meas_err_i(meas_err),
        .coef_sel_i(coef_sel), .coef_o(coef),
        .conv_data_i(conv_data), .conv_valid_i(conv_valid),
        .data_o(data_out), .data_valid_o(data_valid), .data_inspec_o(data_inspec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [EW-1:0] exp_err(input int s, input int r);
        int v;
        v = (s * 613 + r * 389 + 2048) % 4096;
        return v[EW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Busy length monitor.
    initial forever begin
        @(negedge clk);
        if (busy) busy_cnt++;
    end

    // Measurement responder: valid after lat extra cycles of request.
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            if (meas_req) begin
                if (w == lat) begin
                    int st;
                    st = int'(meas_stage);
                    check(st == NST - 1 - idx, "R3", "stage order", st, NST - 1 - idx);
                    if (st < NST - 1) begin
                        coef_sel = 2'(st + 1);
                        #1;
                        check(coef == exp_err(st + 1, run_id), "R4", "prior coef readable",
                              int'(coef), int'(exp_err(st + 1, run_id)));
                    end else begin
                        #1;
                    end
                    meas_err   = exp_err(st, run_id);
                    meas_valid = 1'b1;
                    if (abort_last && st == 0) rst_n = 1'b0;
                    idx++;
                    w = 0;
                end else begin
                    meas_valid = 1'b0;
                    w++;
                end
            end else begin
                meas_valid = 1'b0;
                w = 0;
            end
        end
    end

    task automatic check_coefs_zero(input string req);
        for (int s = 0; s < NST; s++) begin
            coef_sel = 2'(s);
            #1;
            check(coef == '0, req, "coef wiped", int'(coef), 0);
        end
    endtask

    // Raise the request for h falling edges (keep=1 leaves it high) and
    // judge the start timing; returns at the sixth falling edge.
    task automatic start_run(input int h, input int l, input bit keep);
        lat = l;
        idx = 0;
        run_id++;
        @(posedge clk); #1;
        busy_cnt = 0;
        cal_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 2) check(busy == 1'b0, "R1", "busy before third edge", busy, 0);
            if (i >= 3) check(busy == (h >= 3), "R1", "busy after qualification", busy, h >= 3);
            if (i == 5 && h >= 3) begin
                conv_valid = 1'b1;
                conv_data  = 14'h2A5C;
                #1;
                check(data_valid == 1'b0, "R9", "valid muted", data_valid, 0);
                check(data_out == '0, "R9", "data muted", int'(data_out), 0);
            end
            if (i + 1 == h && !keep) begin
                @(posedge clk); #1;
                cal_req = 1'b0;
            end
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run(input int l);
        wait_idle();
        check(busy_cnt == NST * (SET + l + 1), "R8", "busy length", busy_cnt, NST * (SET + l + 1));
        check(idx == NST, "R2", "all stages measured", idx, NST);
        check(calibrated == 1'b1, "R10", "calibrated after run", calibrated, 1);
        for (int s = 0; s < NST; s++) begin
            coef_sel = 2'(s);
            #1;
            check(coef == exp_err(s, run_id), "R4", "stored coef", int'(coef), int'(exp_err(s, run_id)));
        end
        conv_valid = 1'b1;
        conv_data  = 14'h1357;
        #1;
        check(data_valid && data_out == 14'h1357, "R9", "pass-through", int'(data_out), 'h1357);
        check(data_inspec == 1'b1, "R10", "in spec after run", data_inspec, 1);
    endtask

    initial begin
        // Reset state.
        repeat (3) @(posedge clk);
        #1;
        conv_valid = 1'b1;
        conv_data  = 14'h0ABC;
        @(negedge clk);
        check(busy == 1'b0, "R5", "busy in reset", busy, 0);
        check(calibrated == 1'b0, "R5", "calibrated in reset", calibrated, 0);
        check(meas_req == 1'b0, "R4", "no request in reset", meas_req, 0);
        check_coefs_zero("R5");
        check(data_valid && data_out == 14'h0ABC, "R9", "idle pass-through", int'(data_out), 'h0ABC);
        check(data_inspec == 1'b0, "R10", "not in spec before calibration", data_inspec, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Qualification sweep: 1..5 falling edges.
        for (int h = 1; h <= 5; h++) begin
            start_run(h, (h + 1) % 4, 1'b0);
            if (h < 3) begin
                repeat (6) begin
                    @(negedge clk);
                    check(busy == 1'b0 && idx == 0, "R1", "short request ignored", busy, 0);
                end
                run_id--;
            end else begin
                finish_run((h + 1) % 4);
            end
            repeat (2) @(posedge clk);
        end

        // Response latency sweep.
        for (int l = 0; l < 4; l++) begin
            start_run(3, l, 1'b0);
            finish_run(l);
            repeat (2) @(posedge clk);
        end

        // Request activity during busy is ignored.
        start_run(3, 1, 1'b1);
        @(posedge clk); #1;
        cal_req = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        cal_req = 1'b1;
        finish_run(1);
        repeat (8) begin
            @(negedge clk);
            check(busy == 1'b0, "R7", "no restart while request held", busy, 0);
        end
        @(posedge clk); #1;
        cal_req = 1'b0;
        repeat (2) @(posedge clk);

        // Abort mid-run, request held high.
        start_run(3, 0, 1'b1);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R5", "busy before abort", busy, 1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R5", "busy after abort", busy, 0);
        check(calibrated == 1'b0, "R5", "calibrated after abort", calibrated, 0);
        check_coefs_zero("R5");
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check(busy == 1'b0, "R6", "no resume after abort", busy, 0);
        end
        @(posedge clk); #1;
        cal_req = 1'b0;
        repeat (2) @(posedge clk);
        start_run(3, 0, 1'b0);
        finish_run(0);
        repeat (2) @(posedge clk);

        // Reset coinciding with the final coefficient write.
        abort_last = 1'b1;
        start_run(3, 2, 1'b0);
        wait_idle();
        check(calibrated == 1'b0, "R5", "reset beats completion", calibrated, 0);
        check_coefs_zero("R5");
        abort_last = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule